// File: doc/BRIEF.md
# Fast-Serial Byte Sender

This block puts one byte on a three-wire open-collector serial bus. A start strobe hands it a byte and a two-bit flag field. Unless the flags say to skip it, the block first holds off until the bus clock line reaches the level the flags ask for. It then clocks the byte out as eight low pulses on the service-request line, with each bit on the data line. While it waits, it also watches the attention line. If attention goes active before the clock level arrives, the block gives up on the byte without driving anything and reports that in a status bit.

All bus signals are seen from the block's side of the buffers. Each output is a pull-low request: 1 pulls the wire low and 0 releases it. Each input is a bus level that has already been synchronised. One half-period of the service-request clock is a parameter counted in system clock cycles. At the default of 200 cycles on a 50 MHz clock it gives the 4 µs half-period of the bus. The parameter must be at least 2. A controller starts one byte at a time and waits for `done_o`. `atn_seen_o` is read in the same cycle as `done_o`.

Top module: `fstx_byte_sender`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `atn_seen_o` are 0, and both drive outputs are 0 (released).
- R2: With flag bit 1 set, the block transmits without regard to `clk_lvl_i` and `atn_act_i`. The service-request line is first pulled low in the third cycle after the cycle that sampled the start strobe.
- R3: With flag bits 1 and 0 equal to 01, the block waits while `clk_lvl_i` is 0 (clock asserted). Transmission begins once `clk_lvl_i` is 1 (released).
- R4: With flag bits 1 and 0 equal to 00, the block waits while `clk_lvl_i` is 1. Transmission begins once `clk_lvl_i` is 0.
- R5: While the block is waiting (flag bit 1 clear), `atn_act_i`=1 ends the operation in the next cycle with `done_o` and `atn_seen_o` both 1, and neither line is ever driven. If attention and the awaited clock level arrive in the same cycle, attention wins.
- R6: A transmitted byte appears as exactly 8 low pulses on `srq_drv_o`. Each pulse lasts HALF_CYC cycles, and consecutive pulses are separated by HALF_CYC released cycles. The last pulse is also followed by HALF_CYC released cycles before `done_o`.
- R7: Bits go out MSB first, and `data_drv_o` is the inverse of the bit (a 0 bit pulls DATA low). Each bit is present in the cycle before its SRQ pull, stays stable through the pull, and is still present in the first cycle after SRQ is released.
- R8: `done_o` is a one-cycle pulse when a byte completes or aborts. In that cycle and afterwards, both drive outputs are released and `busy_o` is 0. `atn_seen_o` is 0 after a completed byte.
- R9: A start strobe that arrives while `busy_o` is 1 is ignored. The byte in flight is unchanged, and no second operation follows.
- R10: `busy_o` is 1 from the cycle after an accepted start until the operation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| data_i | input | 8 | Byte to send, captured with the start strobe |
| flags_i | input | 2 | Bit 1: skip the clock-level wait; bit 0: awaited clock level |
| clk_lvl_i | input | 1 | Synchronised bus clock level, 1 = released |
| atn_act_i | input | 1 | Synchronised attention line, 1 = asserted |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| atn_seen_o | output | 1 | Operation ended because attention was found active |
| srq_drv_o | output | 1 | Pull service-request line low |
| data_drv_o | output | 1 | Pull data line low |

## Verification
The wait state has two ways out: a cancel when attention is seen and a launch when the clock level matches, and both can happen in the same cycle. The bench sets up a wait for a released clock. Then, on a single falling clock edge, it raises `clk_lvl_i` and `atn_act_i` together. It expects `done_o` and `atn_seen_o` in the next cycle and no SRQ or DATA pull at any point. A second collision, between a fresh start strobe and a byte already in flight, is provoked mid-byte and judged by the byte that appears on the lines.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_LOW,
    ST_HIGH
  } fstx_state_e;

  // flags_i[1] = skip, flags_i[0] = awaited clock level
  typedef struct packed {
    logic skip;
    logic lvl;
  } fstx_flags_t;

endpackage

// File: rtl/fstx_gate.sv
module fstx_gate
  import fstx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        active_i,
  input  fstx_flags_t flags_i,
  input  logic        clk_lvl_i,
  input  logic        atn_act_i,
  output logic        go_o,
  output logic        abort_o
);

  // attention outranks a matching clock level
  assign abort_o = active_i && !flags_i.skip && atn_act_i;
  assign go_o    = active_i && (flags_i.skip || (!atn_act_i && (clk_lvl_i == flags_i.lvl)));

  p_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_o && abort_o));

  p_skip_go_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && flags_i.skip) |-> go_o);

  p_atn_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !flags_i.skip && atn_act_i) |-> !go_o);

endmodule

// File: rtl/fstx_halfper.sv
module fstx_halfper #(
  parameter int unsigned HALF_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);

  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || (run_i && cnt_q == LAST)) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign first_o = run_i && (cnt_q == '0);
  assign last_o  = run_i && (cnt_q == LAST);

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !clr_i) |=> (cnt_q == '0));

endmodule

// File: rtl/fstx_shreg.sv
module fstx_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         shift_i,
  input  logic         step_i,
  output logic         bit_o,
  output logic         final_o
);

  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= d_i;
      idx_q <= '0;
    end else begin
      if (shift_i) sh_q  <= {sh_q[W-2:0], 1'b0};
      if (step_i)  idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o   = sh_q[W-1];
  assign final_o = (idx_q == IDX_LAST);

  p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !final_o);

  p_idx_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);

endmodule

// File: rtl/fstx_byte_sender.sv
module fstx_byte_sender
  import fstx_pkg::*;
#(
  parameter int unsigned HALF_CYC = 200,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        flags_i,
  input  logic              clk_lvl_i,
  input  logic              atn_act_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              atn_seen_o,
  output logic              srq_drv_o,
  output logic              data_drv_o
);

  fstx_state_e st_q, st_d;
  fstx_flags_t flags_q;
  logic        done_q, atn_q;

  logic go, abort;
  logic t_first, t_last;
  logic cur_bit, bit_final;
  logic load, shift, step, end_tx, tx_on;

  assign load   = (st_q == ST_IDLE) && start_i;
  assign tx_on  = (st_q == ST_LEAD) || (st_q == ST_LOW) || (st_q == ST_HIGH);
  // next bit placed one cycle after SRQ release, never on the last bit
  assign shift  = (st_q == ST_HIGH) && t_first && !bit_final;
  assign step   = (st_q == ST_HIGH) && t_last && !bit_final;
  assign end_tx = (st_q == ST_HIGH) && t_last && bit_final;

  fstx_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (st_q == ST_WAIT),
    .flags_i   (flags_q),
    .clk_lvl_i (clk_lvl_i),
    .atn_act_i (atn_act_i),
    .go_o      (go),
    .abort_o   (abort)
  );

  fstx_halfper #(.HALF_CYC(HALF_CYC)) u_half (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q == ST_LEAD),
    .run_i   ((st_q == ST_LOW) || (st_q == ST_HIGH)),
    .first_o (t_first),
    .last_o  (t_last)
  );

  fstx_shreg #(.W(DATA_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .d_i     (data_i),
    .shift_i (shift),
    .step_i  (step),
    .bit_o   (cur_bit),
    .final_o (bit_final)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_WAIT;
      ST_WAIT: begin
        if (abort)   st_d = ST_IDLE;
        else if (go) st_d = ST_LEAD;
      end
      ST_LEAD: st_d = ST_LOW;
      ST_LOW:  if (t_last) st_d = ST_HIGH;
      ST_HIGH: begin
        if (end_tx)      st_d = ST_IDLE;
        else if (t_last) st_d = ST_LOW;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      flags_q <= '0;
      done_q  <= 1'b0;
      atn_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= abort || end_tx;
      if (load) begin
        flags_q <= fstx_flags_t'(flags_i);
        atn_q   <= 1'b0;
      end else if (abort) begin
        atn_q   <= 1'b1;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign atn_seen_o = atn_q;
  assign srq_drv_o  = (st_q == ST_LOW);
  assign data_drv_o = tx_on && !cur_bit;

  p_done_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!srq_drv_o && !data_drv_o && !busy_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_abort_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (done_o && atn_seen_o));

  p_sent_status_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_tx |=> (done_o && !atn_seen_o));

  p_setup_at_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srq_drv_o) |-> $stable(data_drv_o));

  p_hold_at_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srq_drv_o) |-> $stable(data_drv_o));

  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (st_q != ST_WAIT || $past(st_q) == ST_WAIT));

endmodule

// File: tb/tb_fstx_byte_sender.sv
`timescale 1ns/1ps
module tb_fstx_byte_sender;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] flags = '0;
  logic       clk_lvl = 1'b1;
  logic       atn = 1'b0;
  logic       busy, done, atn_seen, srq_drv, data_drv;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fstx_byte_sender #(.HALF_CYC(HALF), .DATA_W(8)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .data_i     (data),
    .flags_i    (flags),
    .clk_lvl_i  (clk_lvl),
    .atn_act_i  (atn),
    .busy_o     (busy),
    .done_o     (done),
    .atn_seen_o (atn_seen),
    .srq_drv_o  (srq_drv),
    .data_drv_o (data_drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic [7:0] d, input logic [1:0] f);
    @(negedge clk);
    start = 1'b1; data = d; flags = f;
    @(negedge clk);
    start = 1'b0;
  endtask

  // watch the lines until done; optionally strobe start at sample 'poke'
  task automatic collect(input int poke, output logic [7:0] got, output int pulses,
                         output int bad_w, output int bad_s, output logic st, output int drv_any);
    int lo_run = 0;
    int hi_run = 0;
    int guard = 0;
    logic prev_srq = 1'b0;
    logic prev_d = 1'b0;
    logic cur_d = 1'b0;
    bit seen_hi = 1'b0;
    got = '0; pulses = 0; bad_w = 0; bad_s = 0; st = 1'b0; drv_any = 0;
    forever begin
      @(negedge clk);
      guard++;
      start = (guard == poke);
      if (guard == poke) data = 8'h00;
      if (done) begin
        st = atn_seen;
        if (pulses > 0 && hi_run != HALF) bad_w++;
        if (srq_drv || data_drv || busy) bad_s++;
        break;
      end
      if (srq_drv || data_drv) drv_any++;
      if (srq_drv && !prev_srq) begin
        pulses++;
        got = {got[6:0], ~data_drv};
        cur_d = data_drv;
        if (prev_d != data_drv) bad_s++;
        if (seen_hi && hi_run != HALF) bad_w++;
        lo_run = 1;
      end else if (srq_drv) begin
        lo_run++;
        if (data_drv != cur_d) bad_s++;
      end else if (prev_srq) begin
        if (lo_run != HALF) bad_w++;
        if (data_drv != cur_d) bad_s++;
        hi_run = 1;
        seen_hi = 1'b1;
      end else if (seen_hi) begin
        hi_run++;
      end
      prev_srq = srq_drv;
      prev_d = data_drv;
      if (guard > 2000) break;
    end
    start = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int pulses, bad_w, bad_s, drv_any;
    logic st;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && atn_seen == 0, "R1 status", {busy, done, atn_seen}, 0);
    chk(srq_drv == 0 && data_drv == 0, "R1 drive", {srq_drv, data_drv}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R6/R7/R8 sweep of every byte with skip; clock asserted and ATN active must not matter
    clk_lvl = 1'b0; atn = 1'b1;
    for (int v = 0; v < 256; v++) begin
      kick(8'(v), 2'b10);
      collect(0, got, pulses, bad_w, bad_s, st, drv_any);
      chk(got == 8'(v), "R7 byte msb first", got, v);
      chk(pulses == 8, "R6 pulse count", pulses, 8);
      chk(bad_w == 0, "R6 pulse widths", bad_w, 0);
      chk(bad_s == 0, "R7 data stability", bad_s, 0);
      chk(st == 0, "R8 status after send", st, 0);
    end
    atn = 1'b0;

    // R2 latency and R10 busy
    kick(8'h00, 2'b10);
    chk(busy == 1 && srq_drv == 0, "R10 busy after start", {busy, srq_drv}, 2);
    @(negedge clk);
    chk(srq_drv == 0, "R2 no pull in lead cycle", srq_drv, 0);
    @(negedge clk);
    chk(srq_drv == 1, "R2 first pull third cycle", srq_drv, 1);
    collect(0, got, pulses, bad_w, bad_s, st, drv_any);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R8 done one cycle", {done, busy}, 0);

    // R3 wait for released clock
    clk_lvl = 1'b0;
    kick(8'h5C, 2'b01);
    repeat (6) @(negedge clk);
    chk(busy == 1 && srq_drv == 0 && data_drv == 0, "R3 holding", {busy, srq_drv, data_drv}, 4);
    clk_lvl = 1'b1;
    collect(0, got, pulses, bad_w, bad_s, st, drv_any);
    chk(got == 8'h5C && pulses == 8, "R3 sent after release", got, 8'h5C);

    // R4 wait for asserted clock
    clk_lvl = 1'b1;
    kick(8'hE1, 2'b00);
    repeat (6) @(negedge clk);
    chk(busy == 1 && srq_drv == 0, "R4 holding", {busy, srq_drv}, 2);
    clk_lvl = 1'b0;
    collect(0, got, pulses, bad_w, bad_s, st, drv_any);
    chk(got == 8'hE1 && pulses == 8 && bad_w == 0, "R4 sent after assert", got, 8'hE1);

    // R5 abort while waiting
    clk_lvl = 1'b0;
    kick(8'h00, 2'b01);
    repeat (3) @(negedge clk);
    chk(srq_drv == 0 && data_drv == 0, "R5 idle lines in wait", {srq_drv, data_drv}, 0);
    atn = 1'b1;
    @(negedge clk);
    chk(done == 1 && atn_seen == 1, "R5 abort status", {done, atn_seen}, 3);
    chk(srq_drv == 0 && data_drv == 0 && busy == 0, "R5 no drive on abort", {srq_drv, data_drv, busy}, 0);
    atn = 1'b0;
    @(negedge clk);
    chk(done == 0 && srq_drv == 0, "R5 nothing after abort", {done, srq_drv}, 0);

    // R5 attention and matching clock in the same cycle
    clk_lvl = 1'b0;
    kick(8'h00, 2'b01);
    repeat (2) @(negedge clk);
    clk_lvl = 1'b1; atn = 1'b1;
    @(negedge clk);
    chk(done == 1 && atn_seen == 1, "R5 same-cycle atn wins", {done, atn_seen}, 3);
    chk(srq_drv == 0 && data_drv == 0, "R5 same-cycle no drive", {srq_drv, data_drv}, 0);
    atn = 1'b0;
    repeat (3) @(negedge clk);
    chk(srq_drv == 0 && busy == 0, "R5 no late launch", {srq_drv, busy}, 0);

    // R8 status cleared by a later successful byte
    kick(8'h3C, 2'b10);
    collect(0, got, pulses, bad_w, bad_s, st, drv_any);
    chk(st == 0 && got == 8'h3C, "R8 status cleared", st, 0);

    // R9 start during a byte is ignored
    kick(8'hA5, 2'b10);
    collect(7, got, pulses, bad_w, bad_s, st, drv_any);
    chk(got == 8'hA5 && pulses == 8, "R9 byte unchanged", got, 8'hA5);
    repeat (4) @(negedge clk);
    chk(busy == 0 && srq_drv == 0, "R9 no second operation", {busy, srq_drv}, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule